// File: doc/BRIEF.md
# Handshaked Byte-Bus Command Slave

This block is the device-side end of an 8-bit parallel link to a host controller. It runs entirely from the local clock. The host strobes (frame start, host handshake, read/write select and host reset) arrive asynchronously and are synchronised first. Every byte moves under a fully interlocked four-phase handshake, so neither side needs to know the other's speed.

A transaction opens with a rising start strobe. The host then writes a six-byte command frame: an opcode, a register address, and a 32-bit value sent low byte first. The slave performs one access on a simple register-file port. It then hands back eight bytes: a data word and then a status word, each low byte first. Its acknowledge line stays high until the last reply byte has completed.

The pad tristate is brought out as a separate output-enable and output-data pair. The register contents live outside the block. Peripheral registers are addressed as a type base plus a channel index, and the block passes the address through unchanged.

Top module: `byte_link_slave`

## Requirements
- R1: While `rst_n` is low, and for as long as the synchronised `host_rst_n_a` is low, the slave returns to idle: `slv_hs`, `slv_ack` and `bus_oe` are all low.
- R2: A rising edge on `host_start_a` raises `slv_ack`. It stays high until the host handshake of the eighth reply byte has returned low, and then falls.
- R3: Write byte: `slv_hs` stays low until the host raises `host_hs_a`. The slave then captures `bus_in` and raises `slv_hs`. It drops `slv_hs` only after `host_hs_a` has gone low.
- R4: Command bytes are taken in this order: opcode, address, then data bits 7:0, 15:8, 23:16 and 31:24.
- R5: Opcode 0x01 (store) produces exactly one single-cycle `rf_we` pulse, with `rf_addr` and `rf_wdata` taken from the frame. The reply data word echoes the written value.
- R6: Opcode 0x02 (fetch) produces no `rf_we` pulse. The reply data word is `rf_rdata` at the frame address.
- R7: Reply byte k (0..7) is bits 8k+7:8k of {status, data}. The slave drives a byte and raises `slv_hs`. It drops `slv_hs` once the host handshake is high. It keeps `slv_hs` low until the host handshake is low again.
- R8: `bus_oe` is high only during the reply phase while `host_rd_a` is high (1 = host reads). In the reply phase with `host_rd_a` low, `bus_oe` stays low.
- R9: Any other opcode produces no `rf_we` pulse. It replies with data word 0 and status 0x00000001. Opcodes 0x01 and 0x02 reply with status 0.
- R10: A start edge in the middle of a frame discards the partial frame. Byte counting restarts at the opcode, and no register access results from the discarded bytes.
- R11: On a host-written byte, `bus_oe` is low in the cycle before `slv_hs` rises and while `slv_hs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_start_a | input | 1 | Asynchronous frame start strobe from host |
| host_hs_a | input | 1 | Asynchronous host handshake |
| host_rd_a | input | 1 | Asynchronous direction select, 1 = host reads |
| host_rst_n_a | input | 1 | Asynchronous active-low host reset |
| bus_in | input | 8 | Pad input data |
| bus_out | output | 8 | Pad output data |
| bus_oe | output | 1 | Pad output enable |
| slv_hs | output | 1 | Slave handshake |
| slv_ack | output | 1 | Transaction-in-progress acknowledge |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | 8 | Register-file address |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data at `rf_addr` |

## Verification
A table of frames alternates stores, fetches and unknown opcodes. The fetches read back store targets, an address never written, and the target of a rejected unknown opcode. This separates the echoed write value from real read data, and shows that a rejected opcode leaves storage untouched. The data values set the top bit and the low bit separately, so a byte-order fault in either direction shows up. Directed runs then cover a start that cuts a frame short, a host reset in mid-frame, a late read/write select during the reply, and a host handshake held high for extra cycles.

// File: rtl/byte_link_pkg.sv
// Shared types for the byte-link slave: controller states and opcodes.
package byte_link_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RX_REL, ST_RX_ACK,
        ST_EXEC, ST_TX_DRV, ST_TX_HI, ST_TX_LO
    } link_state_e;

    localparam logic [7:0] OP_STORE = 8'h01;
    localparam logic [7:0] OP_FETCH = 8'h02;
endpackage

// File: rtl/byte_link_sync.sv
// Two-flop synchroniser bank for asynchronous host strobes.
// Assumes every strobe level is held for at least two clock periods.
module byte_link_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] d_s
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        // Two-stage resample of one strobe bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta   <= 1'b0;
                d_s[i] <= 1'b0;
            end else begin
                meta   <= d_a[i];
                d_s[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/byte_link_ctrl.sv
// Frame controller: four-phase byte handshakes, command assembly,
// one register access, then the reply bytes. Inputs are already synchronised
// except bus_in. bus_in is sampled only after the host handshake has been seen
// high on two consecutive synchronised samples.
module byte_link_ctrl
    import byte_link_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          WORD     = 32,
    parameter logic [31:0] ERR_CODE = 32'h0000_0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hrst_s,
    input  logic            start_s,
    input  logic            hs_s,
    input  logic            rd_s,
    input  logic [DW-1:0]   bus_in,
    output logic [DW-1:0]   bus_out,
    output logic            bus_oe,
    output logic            slv_hs,
    output logic            slv_ack,
    output logic            tx_phase,
    output logic            rf_we,
    output logic [DW-1:0]   rf_addr,
    output logic [WORD-1:0] rf_wdata,
    input  logic [WORD-1:0] rf_rdata
);
    localparam int WB    = WORD / DW;
    localparam int CMD_N = 2 + WB;
    localparam int RPL_N = 2 * WB;
    localparam int FW    = CMD_N * DW;
    localparam int IW    = $clog2(RPL_N > CMD_N ? RPL_N : CMD_N);

    link_state_e       st;
    logic [IW-1:0]     idx;
    logic [FW-1:0]     frame;
    logic [2*WORD-1:0] reply;
    logic              hs_d, start_d;
    logic [DW-1:0]     cmd;

    assign cmd      = frame[DW-1:0];
    assign rf_addr  = frame[2*DW-1:DW];
    assign rf_wdata = frame[FW-1:2*DW];

    // Edge history of synchronised start and handshake
    always_ff @(posedge clk) begin
        if (!rst_n || !hrst_s) begin
            hs_d    <= 1'b0;
            start_d <= 1'b0;
        end else begin
            hs_d    <= hs_s;
            start_d <= start_s;
        end
    end

    // Main sequencer for receive, execute and transmit phases
    always_ff @(posedge clk) begin
        if (!rst_n || !hrst_s) begin
            st    <= ST_IDLE;
            idx   <= '0;
            frame <= '0;
            reply <= '0;
        end else if (start_s && !start_d) begin
            st  <= ST_RX;
            idx <= '0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_RX: if (hs_s && hs_d) begin
                    frame <= {bus_in, frame[FW-1:DW]};
                    st    <= ST_RX_REL;
                end
                ST_RX_REL: st <= ST_RX_ACK;
                ST_RX_ACK: if (!hs_s) begin
                    if (idx == IW'(CMD_N - 1)) begin
                        idx <= '0;
                        st  <= ST_EXEC;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= ST_RX;
                    end
                end
                ST_EXEC: begin
                    if (cmd == OP_STORE)      reply <= {{WORD{1'b0}}, rf_wdata};
                    else if (cmd == OP_FETCH) reply <= {{WORD{1'b0}}, rf_rdata};
                    else                      reply <= {ERR_CODE[WORD-1:0], {WORD{1'b0}}};
                    st <= ST_TX_DRV;
                end
                ST_TX_DRV: st <= ST_TX_HI;
                ST_TX_HI:  if (hs_s) st <= ST_TX_LO;
                ST_TX_LO: if (!hs_s) begin
                    if (idx == IW'(RPL_N - 1)) begin
                        st <= ST_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= ST_TX_DRV;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the sequencer state
    always_comb begin
        tx_phase = (st == ST_TX_DRV) || (st == ST_TX_HI) || (st == ST_TX_LO);
        slv_hs   = (st == ST_RX_ACK) || (st == ST_TX_HI);
        slv_ack  = (st != ST_IDLE);
        bus_oe   = tx_phase && rd_s;
        bus_out  = reply[idx*DW +: DW];
        rf_we    = (st == ST_EXEC) && (cmd == OP_STORE);
    end
endmodule

// File: rtl/byte_link_slave.sv
// Top of the byte-link command slave: synchronises the host strobes and
// hands them to the frame controller. The pad tristate is left to the pad ring.
module byte_link_slave #(
    parameter int          DW       = 8,
    parameter int          WORD     = 32,
    parameter logic [31:0] ERR_CODE = 32'h0000_0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_start_a,
    input  logic            host_hs_a,
    input  logic            host_rd_a,
    input  logic            host_rst_n_a,
    input  logic [DW-1:0]   bus_in,
    output logic [DW-1:0]   bus_out,
    output logic            bus_oe,
    output logic            slv_hs,
    output logic            slv_ack,
    output logic            rf_we,
    output logic [DW-1:0]   rf_addr,
    output logic [WORD-1:0] rf_wdata,
    input  logic [WORD-1:0] rf_rdata
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] strobes_s;
    logic             tx_phase;

    byte_link_sync #(.W(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   ({host_rst_n_a, host_rd_a, host_hs_a, host_start_a}),
        .d_s   (strobes_s)
    );

    byte_link_ctrl #(.DW(DW), .WORD(WORD), .ERR_CODE(ERR_CODE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hrst_s   (strobes_s[3]),
        .start_s  (strobes_s[0]),
        .hs_s     (strobes_s[1]),
        .rd_s     (strobes_s[2]),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .slv_hs   (slv_hs),
        .slv_ack  (slv_ack),
        .tx_phase (tx_phase),
        .rf_we    (rf_we),
        .rf_addr  (rf_addr),
        .rf_wdata (rf_wdata),
        .rf_rdata (rf_rdata)
    );
endmodule

// File: rtl/byte_link_slave_chk.sv
// Protocol checker for byte_link_slave, bound into every instance.
module byte_link_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic slv_hs,
    input logic slv_ack,
    input logic bus_oe,
    input logic rf_we,
    input logic tx_phase
);
    logic rst_q;

    // Remembers that reset was applied at the previous edge
    always_ff @(posedge clk) rst_q <= !rst_n;

    // R1: outputs idle one edge after reset
    always @(posedge clk) begin
        if (rst_q === 1'b1)
            a_r1_idle_after_reset: assert (!slv_hs && !slv_ack && !bus_oe);
    end

    a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    a_r5_we_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (slv_ack && !slv_hs));

    a_r8_oe_reply_only: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (tx_phase && slv_ack));

    a_r11_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(slv_hs) && !tx_phase) |-> (!bus_oe && !$past(bus_oe)));

    a_r2_ack_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slv_ack) |-> !slv_hs);
endmodule

bind byte_link_slave byte_link_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slv_hs   (slv_hs),
    .slv_ack  (slv_ack),
    .bus_oe   (bus_oe),
    .rf_we    (rf_we),
    .tx_phase (tx_phase)
);

// File: tb/test_byte_link_slave.sv
module test_byte_link_slave;
    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] edata;
        logic [31:0] estat;
        logic        ewe;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h10, 32'h1234_5678, 32'h1234_5678, 32'h0, 1'b1},
        '{8'h02, 8'h10, 32'h0,         32'h1234_5678, 32'h0, 1'b0},
        '{8'h02, 8'h33, 32'h0,         32'hC0DE_0033, 32'h0, 1'b0},
        '{8'h7F, 8'h10, 32'hFFFF_FFFF, 32'h0,         32'h1, 1'b0},
        '{8'h02, 8'h10, 32'h0,         32'h1234_5678, 32'h0, 1'b0},
        '{8'h01, 8'h21, 32'h8000_0001, 32'h8000_0001, 32'h0, 1'b1},
        '{8'h02, 8'h21, 32'h0,         32'h8000_0001, 32'h0, 1'b0},
        '{8'h00, 8'h21, 32'h5555_AAAA, 32'h0,         32'h1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_start_a = 1'b0, host_hs_a = 1'b0, host_rd_a = 1'b0, host_rst_n_a = 1'b1;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out, rf_addr;
    logic        bus_oe, slv_hs, slv_ack, rf_we;
    logic [31:0] rf_wdata, rf_rdata;
    logic [31:0] mem [256];
    logic [255:0] written = '0;
    int          we_cnt = 0;
    int          ntot = 0, nbad = 0;

    always #4 clk = ~clk;

    byte_link_slave i_byte_link_slave (
        .clk(clk), .rst_n(rst_n), .host_start_a(host_start_a), .host_hs_a(host_hs_a),
        .host_rd_a(host_rd_a), .host_rst_n_a(host_rst_n_a), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .slv_hs(slv_hs), .slv_ack(slv_ack),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // Register-file model: unwritten locations read C0DE00aa
    assign rf_rdata = written[rf_addr] ? mem[rf_addr] : (32'hC0DE_0000 | {24'h0, rf_addr});
    always @(posedge clk) begin
        if (rf_we) begin
            mem[rf_addr]     <= rf_wdata;
            written[rf_addr] <= 1'b1;
            we_cnt           <= we_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        ntot++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_out(input bit use_ack, input bit lvl, input string req);
        int n = 0;
        while (((use_ack ? slv_ack : slv_hs) !== lvl) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk(1'b0, req, {63'h0, ~lvl}, {63'h0, lvl});
    endtask

    task automatic pulse_start();
        @(negedge clk); host_start_a = 1'b1;
        repeat (4) @(negedge clk);
        host_start_a = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Host-to-slave byte (R3, R11)
    task automatic wr_byte(input logic [7:0] b);
        bus_in = b; host_rd_a = 1'b0;
        repeat (3) @(negedge clk);
        chk(slv_hs == 1'b0, "R3 hs before host", {63'h0, slv_hs}, 64'h0);
        host_hs_a = 1'b1;
        wait_out(1'b0, 1'b1, "R3 hs rise");
        chk(bus_oe == 1'b0, "R11 bus released", {63'h0, bus_oe}, 64'h0);
        host_hs_a = 1'b0;
        wait_out(1'b0, 1'b0, "R3 hs fall");
    endtask

    // Slave-to-host byte (R7, R8); late=1 holds read select low at first
    task automatic rd_byte(input bit late, output logic [7:0] b);
        wait_out(1'b0, 1'b1, "R7 reply hs");
        if (late) begin
            chk(bus_oe == 1'b0, "R8 oe with write select", {63'h0, bus_oe}, 64'h0);
            host_rd_a = 1'b1;
            repeat (4) @(negedge clk);
            chk(bus_oe == 1'b1, "R8 oe with read select", {63'h0, bus_oe}, 64'h1);
        end
        b = bus_out;
        host_hs_a = 1'b1;
        wait_out(1'b0, 1'b0, "R7 hs drop");
        repeat (4) begin
            @(negedge clk);
            chk(slv_hs == 1'b0, "R7 held until host low", {63'h0, slv_hs}, 64'h0);
        end
        host_hs_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic txn(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] wd,
                       input bit late, output logic [31:0] d, output logic [31:0] s);
        logic [63:0] r;
        logic [7:0]  b;
        pulse_start();
        chk(slv_ack == 1'b1, "R2 ack after start", {63'h0, slv_ack}, 64'h1);
        wr_byte(cmd); wr_byte(addr);
        for (int k = 0; k < 4; k++) wr_byte(wd[8*k +: 8]);
        host_rd_a = !late;
        for (int k = 0; k < 8; k++) begin
            rd_byte(late && k == 0, b);
            r[8*k +: 8] = b;
        end
        wait_out(1'b1, 1'b0, "R2 ack fall");
        host_rd_a = 1'b0;
        d = r[31:0];
        s = r[63:32];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 64'h0, 64'h1);
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        logic [31:0] d, s;
        int w0;
        repeat (3) @(negedge clk);
        chk({slv_hs, slv_ack, bus_oe} == 3'b000, "R1 reset idle", {61'h0, slv_hs, slv_ack, bus_oe}, 64'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Table of frames (R4, R5, R6, R9)
        for (int v = 0; v < NV; v++) begin
            w0 = we_cnt;
            txn(VECS[v].cmd, VECS[v].addr, VECS[v].wdata, 1'b0, d, s);
            chk(d == VECS[v].edata, "R4/R5/R6 data word", {32'h0, d}, {32'h0, VECS[v].edata});
            chk(s == VECS[v].estat, "R9 status word", {32'h0, s}, {32'h0, VECS[v].estat});
            chk((we_cnt - w0) == int'(VECS[v].ewe), "R5/R9 write count",
                64'(we_cnt - w0), {63'h0, VECS[v].ewe});
        end

        // R10: start inside a frame discards partial bytes
        pulse_start();
        wr_byte(8'h01); wr_byte(8'h44); wr_byte(8'hAA);
        w0 = we_cnt;
        txn(8'h01, 8'h45, 32'h0BAD_F00D, 1'b0, d, s);
        chk(d == 32'h0BAD_F00D && s == 32'h0, "R10 restarted frame", {d, s}, {32'h0BAD_F00D, 32'h0});
        chk(we_cnt - w0 == 1, "R10 one write", 64'(we_cnt - w0), 64'h1);
        txn(8'h02, 8'h44, 32'h0, 1'b0, d, s);
        chk(d == 32'hC0DE_0044, "R10 aborted addr untouched", {32'h0, d}, 64'hC0DE_0044);
        txn(8'h02, 8'h45, 32'h0, 1'b0, d, s);
        chk(d == 32'h0BAD_F00D, "R10 new addr written", {32'h0, d}, 64'h0BAD_F00D);

        // R8: late read select during reply
        txn(8'h02, 8'h21, 32'h0, 1'b1, d, s);
        chk(d == 32'h8000_0001, "R8 late select data", {32'h0, d}, 64'h8000_0001);

        // R1: host reset in mid-frame
        pulse_start();
        wr_byte(8'h01); wr_byte(8'h50);
        host_rst_n_a = 1'b0;
        repeat (6) @(negedge clk);
        chk({slv_hs, slv_ack, bus_oe} == 3'b000, "R1 host reset idle", {61'h0, slv_hs, slv_ack, bus_oe}, 64'h0);
        host_rst_n_a = 1'b1;
        repeat (5) @(negedge clk);
        txn(8'h02, 8'h10, 32'h0, 1'b0, d, s);
        chk(d == 32'h1234_5678 && s == 32'h0, "R1 recovery after host reset", {d, s}, {32'h1234_5678, 32'h0});

        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule